// File: doc/BRIEF.md
# Protected Memory Region Access Filter

This block sits in the path of every memory transaction and decides whether the transaction may proceed. A transaction presents an address, a read/write flag and a source class code. Eight programmable regions each cover a span of 1 KiB pages between two inclusive page bounds. Each region has its own read permission mask and write permission mask, with one bit per source class. A transaction that lands in an enabled region without the permission it needs is refused. The refusal raises a one-cycle violation pulse, which the reset controller uses as a full system reset request.

Seven source classes exist: SRAM flush (code 0), CPU snoop (1), CPU in secure management mode (2), CPU in normal mode (3), the management unit (4), virtual channel 0 (5) and virtual channel 1 (6). Code 7 is reserved. All DMA-capable peripheral traffic arrives as virtual channel 0, so clearing write-mask bit 5 in a region keeps DMA writes out of it. Snoops are checked only for writes.

Software or firmware sets the regions up through a small register port. `cfg_addr` is `{log_sel, region[2:0], field[2:0]}`. The field codes are 0 for the low page, 1 for the high page, 2 for the read mask, 3 for the write mask and 4 for control, where bit 0 is enable and bit 1 is lock. With `log_sel` = 1, word 0 reads the captured violation address and word 1 reads the capture status `{region[7:5], source[4:2], write[1], valid[0]}`. Any write with `log_sel` = 1 clears the capture.

Top module: `mem_region_guard`

## Requirements
- R1: A transaction is inside a region when low <= addr[31:10] <= high. Both bounds are inclusive, and address bits 9:0 take no part in the compare.
- R2: A region whose enable bit is 0 never matches. After reset no region is enabled, so every transaction is granted.
- R3: A read needs bit `src` of the read mask, and a write needs bit `src` of the write mask, in every enabled region it falls inside.
- R4: A read from the snoop class (code 1) is never refused, whatever the read mask holds. A snoop write is checked against the write mask.
- R5: When several enabled regions contain the address, the transaction is granted only if every one of them permits it.
- R6: `req_grant` follows the current request combinationally. It is 1 only while `req_valid` is 1 and the transaction is permitted.
- R7: `viol_pulse` is 1 for exactly the cycle after a refused valid request, and 0 at all other times.
- R8: The first refusal captures the full address, the source code, the write flag and the lowest-numbered matching region. Later refusals leave the capture unchanged until it is cleared.
- R9: A configuration write with `cfg_addr[6]` = 1 empties the capture, so the status word reads 0.
- R10: Once a region's lock bit is written as 1, further writes to that region's bounds, masks and control are ignored until reset.
- R11: After reset, all bounds, masks, enables and locks are 0, the capture is empty and `viol_pulse` is 0.
- R12: `cfg_rdata` presents the word selected by `cfg_addr` one clock edge later.
- R13: The reserved source code 7 is refused for both reads and writes in any enabled region that contains the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transaction present |
| req_addr | input | 32 | Transaction byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_src | input | 3 | Source class code |
| req_grant | output | 1 | Transaction may proceed (combinational) |
| viol_pulse | output | 1 | Registered refusal pulse, requests a system reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word select |
| cfg_wdata | input | 22 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |

## Verification
The embedded assertions check several properties on every cycle. Each refused request is followed by a pulse, and every pulse has a refused request behind it. Snoop reads are always granted. A held capture never changes until it is cleared, a clear empties the capture, and a locked region keeps its lock and bounds. Some behaviour can only be shown by the bench scenarios, because it depends on what was programmed. These scenarios cover inclusive bound edges, per-class mask decoding, overlap between regions, the contents of the capture including the lowest-index rule, the reserved code, writes ignored under lock, and the return to defaults on reset.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

  localparam logic [2:0] SRC_FLUSH   = 3'd0;
  localparam logic [2:0] SRC_SNOOP   = 3'd1;
  localparam logic [2:0] SRC_CPU_SEC = 3'd2;
  localparam logic [2:0] SRC_CPU_NRM = 3'd3;
  localparam logic [2:0] SRC_MGMT    = 3'd4;
  localparam logic [2:0] SRC_VC0     = 3'd5;
  localparam logic [2:0] SRC_VC1     = 3'd6;
  localparam logic [2:0] SRC_RSVD    = 3'd7;

  localparam int FIELD_W = 3;

  typedef enum logic [FIELD_W-1:0] {
    FLD_LOW   = 3'd0,
    FLD_HIGH  = 3'd1,
    FLD_RMASK = 3'd2,
    FLD_WMASK = 3'd3,
    FLD_CTRL  = 3'd4
  } field_e;

endpackage

// File: rtl/mrg_region_bank.sv
module mrg_region_bank #(
  parameter int NREG = 8,
  parameter int BW   = 22,
  parameter int NSRC = 7,
  parameter int IDXW = 3,
  parameter int FW   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDXW-1:0]            wr_region,
  input  logic [FW-1:0]              wr_field,
  input  logic [BW-1:0]              wr_data,
  output logic [NREG-1:0][BW-1:0]    lo_q,
  output logic [NREG-1:0][BW-1:0]    hi_q,
  output logic [NREG-1:0][NSRC-1:0]  rmask_q,
  output logic [NREG-1:0][NSRC-1:0]  wmask_q,
  output logic [NREG-1:0]            en_q,
  output logic [NREG-1:0]            lock_q
);
  import mrg_pkg::*;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_region == IDXW'(i)) && !lock_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[i]    <= '0;
        hi_q[i]    <= '0;
        rmask_q[i] <= '0;
        wmask_q[i] <= '0;
        en_q[i]    <= 1'b0;
        lock_q[i]  <= 1'b0;
      end else if (sel) begin
        case (wr_field)
          FLD_LOW:   lo_q[i]    <= wr_data;
          FLD_HIGH:  hi_q[i]    <= wr_data;
          FLD_RMASK: rmask_q[i] <= wr_data[NSRC-1:0];
          FLD_WMASK: wmask_q[i] <= wr_data[NSRC-1:0];
          FLD_CTRL: begin
            en_q[i]   <= wr_data[0];
            lock_q[i] <= wr_data[1];
          end
          default: ;
        endcase
      end
    end

    // R10: a locked region keeps its lock and its bounds until reset
    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (rst)
      lock_q[i] |=> (lock_q[i] && $stable(lo_q[i]) && $stable(hi_q[i])
                     && $stable(wmask_q[i]) && $stable(en_q[i])));
  end

endmodule

// File: rtl/mrg_region_cmp.sv
module mrg_region_cmp #(
  parameter int BW   = 22,
  parameter int NSRC = 7,
  parameter int SRCW = 3
) (
  input  logic            en,
  input  logic [BW-1:0]   lo,
  input  logic [BW-1:0]   hi,
  input  logic [NSRC-1:0] rmask,
  input  logic [NSRC-1:0] wmask,
  input  logic [BW-1:0]   page,
  input  logic            write,
  input  logic [SRCW-1:0] src,
  output logic            hit,
  output logic            block
);
  import mrg_pkg::*;

  localparam int EXTW = 1 << SRCW;

  logic [EXTW-1:0] rext, wext;
  logic            allow;

  always_comb begin
    rext = '0;
    wext = '0;
    rext[NSRC-1:0] = rmask;
    wext[NSRC-1:0] = wmask;
    hit = en && (page >= lo) && (page <= hi);
    if (write)
      allow = wext[src];
    else if (src == SRC_SNOOP)
      allow = 1'b1;
    else
      allow = rext[src];
    block = hit && !allow;
  end

endmodule

// File: rtl/mrg_violation_log.sv
module mrg_violation_log #(
  parameter int AW   = 32,
  parameter int SRCW = 3,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            deny,
  input  logic            clear,
  input  logic [AW-1:0]   addr,
  input  logic [SRCW-1:0] src,
  input  logic            write,
  input  logic [IDXW-1:0] region,
  output logic            pulse,
  output logic            log_valid,
  output logic [AW-1:0]   log_addr,
  output logic [SRCW-1:0] log_src,
  output logic            log_write,
  output logic [IDXW-1:0] log_region
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse      <= 1'b0;
      log_valid  <= 1'b0;
      log_addr   <= '0;
      log_src    <= '0;
      log_write  <= 1'b0;
      log_region <= '0;
    end else begin
      pulse <= deny;
      if (clear) begin
        log_valid  <= 1'b0;
        log_addr   <= '0;
        log_src    <= '0;
        log_write  <= 1'b0;
        log_region <= '0;
      end else if (deny && !log_valid) begin
        log_valid  <= 1'b1;
        log_addr   <= addr;
        log_src    <= src;
        log_write  <= write;
        log_region <= region;
      end
    end
  end

  // R8: a held capture is never overwritten
  a_r8_capture_held: assert property (@(posedge clk) disable iff (rst)
    (log_valid && !clear) |=> (log_valid && $stable(log_addr) && $stable(log_src)
                               && $stable(log_region) && $stable(log_write)));

  // R9: a clear empties the capture
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clear |=> !log_valid);

endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int GRAN = 10,
  parameter int NSRC = 7,
  parameter int SRCW = 3,
  parameter int DW   = 32,
  localparam int BW   = AW - GRAN,
  localparam int IDXW = $clog2(NREG),
  localparam int FW   = 3,
  localparam int CAW  = 1 + IDXW + FW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic [SRCW-1:0] req_src,
  output logic            req_grant,
  output logic            viol_pulse,
  input  logic            cfg_we,
  input  logic [CAW-1:0]  cfg_addr,
  input  logic [BW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata
);
  import mrg_pkg::*;

  logic [NREG-1:0][BW-1:0]   lo_q, hi_q;
  logic [NREG-1:0][NSRC-1:0] rmask_q, wmask_q;
  logic [NREG-1:0]           en_q, lock_q;

  logic                      log_sel;
  logic [IDXW-1:0]           cfg_region;
  logic [FW-1:0]             cfg_field;

  assign log_sel    = cfg_addr[CAW-1];
  assign cfg_region = cfg_addr[FW +: IDXW];
  assign cfg_field  = cfg_addr[FW-1:0];

  mrg_region_bank #(
    .NREG(NREG), .BW(BW), .NSRC(NSRC), .IDXW(IDXW), .FW(FW)
  ) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we && !log_sel),
    .wr_region(cfg_region),
    .wr_field(cfg_field),
    .wr_data(cfg_wdata),
    .lo_q(lo_q), .hi_q(hi_q),
    .rmask_q(rmask_q), .wmask_q(wmask_q),
    .en_q(en_q), .lock_q(lock_q)
  );

  logic [BW-1:0]   page;
  logic [NREG-1:0] hit_vec, block_vec;

  assign page = req_addr[AW-1:GRAN];

  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    mrg_region_cmp #(.BW(BW), .NSRC(NSRC), .SRCW(SRCW)) u_cmp (
      .en(en_q[i]), .lo(lo_q[i]), .hi(hi_q[i]),
      .rmask(rmask_q[i]), .wmask(wmask_q[i]),
      .page(page), .write(req_write), .src(req_src),
      .hit(hit_vec[i]), .block(block_vec[i])
    );
  end

  logic            deny;
  logic [IDXW-1:0] first_hit;

  always_comb begin
    first_hit = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit_vec[i]) first_hit = IDXW'(i);
    end
  end

  assign deny      = req_valid && (|block_vec);
  assign req_grant = req_valid && !(|block_vec);

  logic            log_valid, log_write;
  logic [AW-1:0]   log_addr;
  logic [SRCW-1:0] log_src;
  logic [IDXW-1:0] log_region;

  mrg_violation_log #(.AW(AW), .SRCW(SRCW), .IDXW(IDXW)) u_log (
    .clk(clk), .rst(rst),
    .deny(deny), .clear(cfg_we && log_sel),
    .addr(req_addr), .src(req_src), .write(req_write), .region(first_hit),
    .pulse(viol_pulse),
    .log_valid(log_valid), .log_addr(log_addr), .log_src(log_src),
    .log_write(log_write), .log_region(log_region)
  );

  logic [DW-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (log_sel) begin
      if (cfg_field[0])
        rd_next = DW'({log_region, log_src, log_write, log_valid});
      else
        rd_next = DW'(log_addr);
    end else begin
      case (cfg_field)
        FLD_LOW:   rd_next = DW'(lo_q[cfg_region]);
        FLD_HIGH:  rd_next = DW'(hi_q[cfg_region]);
        FLD_RMASK: rd_next = DW'(rmask_q[cfg_region]);
        FLD_WMASK: rd_next = DW'(wmask_q[cfg_region]);
        FLD_CTRL:  rd_next = DW'({lock_q[cfg_region], en_q[cfg_region]});
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_next;
  end

  // R7: every refused request produces a pulse on the next cycle
  a_r7_pulse_after_refusal: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_grant) |=> viol_pulse);

  // R7: a pulse only ever follows a refused request
  a_r7_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |-> $past(req_valid && !req_grant));

  // R4: snoop reads always pass
  a_r4_snoop_read_free: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_src == SRC_SNOOP) |-> req_grant);

endmodule

// File: tb/mem_region_guard_test.sv
`timescale 1ns/1ps
module mem_region_guard_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [2:0]  req_src = '0;
  logic        req_grant, viol_pulse;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [21:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic  grant;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  mem_region_guard uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_src(req_src),
    .req_grant(req_grant), .viol_pulse(viol_pulse),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  // Monitor: pulse expected one cycle after each refusal (R7), grant per queued item
  logic pend = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (viol_pulse !== pend) begin
        errors++;
        $display("FAIL R7 viol_pulse actual=%0b expected=%0b", viol_pulse, pend);
      end
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (req_grant !== e.grant) begin
          errors++;
          $display("FAIL %s grant actual=%0b expected=%0b addr=%h",
                   e.tag, req_grant, e.grant, req_addr);
        end
        pend = !e.grant;
      end else begin
        checks++;
        if (req_grant !== 1'b0) begin
          errors++;
          $display("FAIL R6 grant without request actual=%0b expected=0", req_grant);
        end
        pend = 1'b0;
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic w, input logic [2:0] s,
                       input logic g, input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_write = w; req_src = s;
    cfg_we = 1'b0;
    e.grant = g; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg_write(input logic [6:0] a, input logic [21:0] d);
    @(posedge clk); #1;
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    req_valid = 1'b0; cfg_we = 1'b0; cfg_addr = a;
    @(posedge clk); #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read addr=%0d actual=%h expected=%h", tag, a, cfg_rdata, exp);
    end
  endtask

  task automatic prog(input int r, input logic [21:0] lo, input logic [21:0] hi,
                      input logic [6:0] rm, input logic [6:0] wm, input logic [1:0] ctl);
    cfg_write(7'(r * 8 + 0), lo);
    cfg_write(7'(r * 8 + 1), hi);
    cfg_write(7'(r * 8 + 2), {15'd0, rm});
    cfg_write(7'(r * 8 + 3), {15'd0, wm});
    cfg_write(7'(r * 8 + 4), {20'd0, ctl});
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    req_valid = 1'b0; cfg_we = 1'b0; rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (req_grant !== 1'b0 || viol_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R11 outputs after reset actual=%0b%0b expected=00", req_grant, viol_pulse);
    end
    mon_on = 1'b1;
    cfg_read(7'd4, 32'd0, "R11");
    cfg_read(7'd0, 32'd0, "R11");
    cfg_read(7'd65, 32'd0, "R11");

    // region 0: pages 0x10..0x1F, read denies normal CPU and snoop, write only secure CPU
    prog(0, 22'h10, 22'h1F, 7'h75, 7'h04, 2'b00);
    issue(32'h4000, 1'b0, 3'd3, 1'b1, "R2");
    idle();
    cfg_write(7'd4, 22'd1);
    issue(32'h4000, 1'b0, 3'd3, 1'b0, "R1");
    issue(32'h3FFF, 1'b0, 3'd3, 1'b1, "R1");
    issue(32'h7FFF, 1'b0, 3'd3, 1'b0, "R1");
    issue(32'h8000, 1'b0, 3'd3, 1'b1, "R1");
    issue(32'h5000, 1'b1, 3'd2, 1'b1, "R3");
    issue(32'h5000, 1'b1, 3'd5, 1'b0, "R3");
    issue(32'h5000, 1'b0, 3'd5, 1'b1, "R3");
    issue(32'h5000, 1'b0, 3'd1, 1'b1, "R4");
    issue(32'h5000, 1'b1, 3'd1, 1'b0, "R4");
    issue(32'h5000, 1'b0, 3'd7, 1'b0, "R13");
    issue(32'h5000, 1'b1, 3'd7, 1'b0, "R13");
    idle();
    cfg_read(7'd64, 32'h4000, "R8");
    cfg_read(7'd65, 32'h0D, "R8");
    cfg_read(7'd2, 32'h75, "R12");
    cfg_write(7'd64, 22'd0);
    cfg_read(7'd65, 32'd0, "R9");

    // region 1 overlaps region 0 and permits everything
    prog(1, 22'h18, 22'h30, 7'h7F, 7'h7F, 2'b01);
    issue(32'h6000, 1'b0, 3'd3, 1'b0, "R5");
    issue(32'h6000, 1'b1, 3'd2, 1'b1, "R5");
    issue(32'h9000, 1'b0, 3'd3, 1'b1, "R5");
    idle();
    cfg_read(7'd64, 32'h6000, "R8");
    cfg_read(7'd65, 32'h0D, "R8");
    cfg_write(7'd64, 22'd0);

    // regions 2 and 3 share one page and deny everything
    prog(2, 22'h40, 22'h40, 7'h00, 7'h00, 2'b01);
    prog(3, 22'h40, 22'h40, 7'h00, 7'h00, 2'b01);
    issue(32'h10000, 1'b1, 3'd6, 1'b0, "R8");
    issue(32'h6000, 1'b0, 3'd3, 1'b0, "R8");
    idle();
    cfg_read(7'd64, 32'h10000, "R8");
    cfg_read(7'd65, 32'h5B, "R8");

    // lock region 2 and try to disable and move it
    cfg_write(7'd20, 22'd3);
    cfg_write(7'd20, 22'd0);
    cfg_write(7'd16, 22'd0);
    cfg_read(7'd20, 32'd3, "R10");
    cfg_read(7'd16, 32'h40, "R10");
    issue(32'h10000, 1'b1, 3'd6, 1'b0, "R10");
    idle();

    do_reset();
    cfg_read(7'd20, 32'd0, "R11");
    cfg_read(7'd16, 32'd0, "R11");
    cfg_read(7'd65, 32'd0, "R11");
    issue(32'h10000, 1'b1, 3'd6, 1'b1, "R2");
    idle();
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule